// File: doc/BRIEF.md
# Normalizing 32-bit Barrel Shifter

This block moves a 32-bit word by any distance from 0 to 31 positions in a single pass. It can rotate left, shift left with zeros entering at the bottom, or shift right with either zeros or copies of the sign bit entering at the top. It serves floating-point mantissa normalization as well as packing, unpacking and extracting bit fields.

A leading-bit encoder looks at the mantissa in either two's-complement or sign-magnitude form. When normalization is requested on a left shift, the encoder's count replaces the external distance, so one pass yields a normalized mantissa. The count and an all-zero flag are also driven on their own ports on every cycle, whatever the operation, so a controller can gather block exponents from them.

The 32-bit result leaves through a 16-bit port. A select input chooses whether that port shows the upper or the lower half. One register stage sits at the input and one at the output. Each stage has its own bypass control, and both share a clock enable and a synchronous reset.

Top module: `norm_shifter`

## Requirements
- R1: With `shift_op` = 2'b00 the result is `data_in` rotated left by `shift_amt` (0 to 31). Bits leaving at bit 31 re-enter at bit 0.
- R2: With `shift_op` = 2'b01 or 2'b11 and `normalize` low, the result is `data_in` shifted left by `shift_amt`, with zeros entering at bit 0.
- R3: With `shift_op` = 2'b10 the result is `data_in` shifted right by `shift_amt`. Vacated upper bits take bit 31 of the data when `fill_sign` is 1, and take 0 when `fill_sign` is 0.
- R4: `data_out` shows result bits 31:16 when `half_sel` is 1 and result bits 15:0 when it is 0. The selection is combinational from the output stage.
- R5: With `normalize` high on a left shift (op 01 or 11) and `sm_mode` low, `shift_amt` is ignored and the whole word is shifted left by the encoder count.
- R6: With `normalize` high on a left shift and `sm_mode` high, bit 31 keeps its value. Bits 30:0 are shifted left by the encoder count, with zero fill.
- R7: `lead_count` is computed for every operation. With `sm_mode` = 0 it counts the consecutive bits from bit 30 downward that equal bit 31. With `sm_mode` = 1 it counts the leading zeros of bits 30:0.
- R8: When no bit of 30:0 differs from the reference (bit 31 in two's-complement mode, 0 in sign-magnitude mode), `lead_count` is 31 and `lead_zero` is 1. Otherwise `lead_zero` is 0.
- R9: With both bypass inputs at 0, inputs reach the outputs after two rising edges. `in_bypass` = 1 makes the input stage transparent, and `out_bypass` = 1 makes the output stage transparent. Each bypass removes one cycle of latency.
- R10: `rst` = 1 at a rising edge clears both stages to zero. While `ce` is 0, neither stage changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of both stages |
| ce | input | 1 | Clock enable shared by both stages |
| in_bypass | input | 1 | 1: input stage transparent |
| out_bypass | input | 1 | 1: output stage transparent |
| data_in | input | 32 | Word to shift |
| shift_amt | input | 5 | External shift distance |
| shift_op | input | 2 | 00 rotate left, 01/11 shift left, 10 shift right |
| fill_sign | input | 1 | Right shift fill: 1 sign bit, 0 zero |
| normalize | input | 1 | Take the distance from the encoder on left shifts |
| sm_mode | input | 1 | Encoder format: 1 sign-magnitude, 0 two's complement |
| half_sel | input | 1 | 1 upper half, 0 lower half of the result |
| data_out | output | 16 | Selected half of the result |
| lead_count | output | 5 | Encoder count |
| lead_zero | output | 1 | No significant bit found |

## Verification
The clocked properties sample combinational shifter and encoder signals. They therefore assume that every input, including both bypass controls, carries a defined 0 or 1 once reset is released. The bench drives every input from time zero and changes inputs only at falling edges. Bypass and enable are changed freely between vectors, because the reference pipeline in the bench follows the same stage semantics. Data patterns are biased toward long runs of leading zeros or ones, so normalization distances across the whole 0 to 31 range, including the all-zero and all-sign cases, are reached.

// File: rtl/norm_shifter_pkg.sv
package norm_shifter_pkg;

  typedef enum logic [1:0] {
    OP_ROTL    = 2'b00,
    OP_SHL     = 2'b01,
    OP_SHR     = 2'b10,
    OP_SHL_ALT = 2'b11
  } shift_op_e;

  typedef struct packed {
    shift_op_e op;
    logic      fill_sign;
    logic      norm;
    logic      sm_mode;
  } shift_ctrl_t;

endpackage

// File: rtl/ns_stage.sv
module ns_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] r_q;

  always_ff @(posedge clk) begin
    if (rst)     r_q <= '0;
    else if (ce) r_q <= d;
  end

  assign q = bypass ? d : r_q;

  // R10: a stage with ce low keeps its contents
  assert_stage_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(ce) && !$past(rst)) |-> $stable(r_q));

  // R10: the cycle after reset the stage holds zero
  assert_stage_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (r_q == '0));

endmodule

// File: rtl/ns_lead_enc.sv
module ns_lead_enc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  data,
  input  logic          sm_mode,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  localparam int MW = W - 1;

  logic          ref_bit;
  logic [MW-1:0] diff;

  assign ref_bit = sm_mode ? 1'b0 : data[W-1];
  assign diff    = data[MW-1:0] ^ {MW{ref_bit}};

  always_comb begin
    cnt = CW'(MW);
    for (int i = 0; i < MW; i++) begin
      if (diff[i]) cnt = CW'(MW - 1 - i);
    end
  end

  assign zero = ~|diff;

  // R8: the zero flag comes with the maximum count
  assert_enc_zero_R8: assert property (@(posedge clk) disable iff (rst)
    zero |-> (cnt == CW'(MW)));

  // R7: the first bit after the counted run differs from the reference
  assert_enc_first_R7: assert property (@(posedge clk) disable iff (rst)
    !zero |-> (data[MW - 1 - int'(cnt)] != ref_bit));

endmodule

// File: rtl/ns_log_shifter.sv
module ns_log_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          rotate,
  input  logic          right,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] lvl [AW+1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = din[W-1-i];
    assign rev_out[i] = lvl[AW][W-1-i];
  end

  assign lvl[0] = right ? rev_in : din;

  for (genvar k = 0; k < AW; k++) begin : g_lvl
    localparam int S = 1 << k;
    logic [S-1:0] low_bits;
    assign low_bits   = rotate ? lvl[k][W-1 -: S] : {S{fill}};
    assign lvl[k+1]   = amt[k] ? {lvl[k][W-1-S:0], low_bits} : lvl[k];
  end

  assign dout = right ? rev_out : lvl[AW];

  // R1: rotation neither creates nor loses set bits
  assert_rot_pop_R1: assert property (@(posedge clk) disable iff (rst)
    rotate |-> ($countones(dout) == $countones(din)));

  // R2: a nonzero zero-filled left shift clears bit 0
  assert_shl_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (!rotate && !right && !fill && amt != '0) |-> !dout[0]);

endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
  import norm_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = DATA_W / 2,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              in_bypass,
  input  logic              out_bypass,
  input  logic [DATA_W-1:0] data_in,
  input  logic [AMT_W-1:0]  shift_amt,
  input  logic [1:0]        shift_op,
  input  logic              fill_sign,
  input  logic              normalize,
  input  logic              sm_mode,
  input  logic              half_sel,
  output logic [HALF_W-1:0] data_out,
  output logic [AMT_W-1:0]  lead_count,
  output logic              lead_zero
);

  localparam int CTRL_W = $bits(shift_ctrl_t);
  localparam int IN_W   = DATA_W + AMT_W + CTRL_W;
  localparam int OUT_W  = DATA_W + AMT_W + 1;

  shift_ctrl_t       c_in, c1;
  logic [DATA_W-1:0] d1;
  logic [AMT_W-1:0]  a1;
  logic [IN_W-1:0]   s1_bus;

  assign c_in = '{op: shift_op_e'(shift_op), fill_sign: fill_sign,
                  norm: normalize, sm_mode: sm_mode};

  ns_stage #(.W(IN_W)) u_in_stage (
    .clk(clk), .rst(rst), .ce(ce), .bypass(in_bypass),
    .d({data_in, shift_amt, c_in}), .q(s1_bus)
  );

  assign {d1, a1, c1} = s1_bus;

  logic [AMT_W-1:0] enc_cnt;
  logic             enc_zero;

  ns_lead_enc #(.W(DATA_W), .CW(AMT_W)) u_enc (
    .clk(clk), .rst(rst), .data(d1), .sm_mode(c1.sm_mode),
    .cnt(enc_cnt), .zero(enc_zero)
  );

  logic              is_rot, is_right, do_norm, keep_sign;
  logic [DATA_W-1:0] sh_in, sh_out, result;
  logic [AMT_W-1:0]  eff_amt;

  assign is_rot    = (c1.op == OP_ROTL);
  assign is_right  = (c1.op == OP_SHR);
  assign do_norm   = c1.norm && !is_rot && !is_right;
  assign keep_sign = do_norm && c1.sm_mode;
  assign eff_amt   = do_norm ? enc_cnt : a1;
  assign sh_in     = keep_sign ? {d1[DATA_W-2:0], 1'b0} : d1;

  ns_log_shifter #(.W(DATA_W), .AW(AMT_W)) u_shift (
    .clk(clk), .rst(rst), .din(sh_in), .amt(eff_amt),
    .rotate(is_rot), .right(is_right),
    .fill(is_right && c1.fill_sign && d1[DATA_W-1]),
    .dout(sh_out)
  );

  assign result = keep_sign ? {d1[DATA_W-1], sh_out[DATA_W-1:1]} : sh_out;

  // R5: a normalized two's-complement word has its top two bits differing
  assert_norm_tc_R5: assert property (@(posedge clk) disable iff (rst)
    (do_norm && !c1.sm_mode && !enc_zero) |-> (result[DATA_W-1] != result[DATA_W-2]));

  // R6: a normalized sign-magnitude word keeps its sign and leads with a one
  assert_norm_sm_R6: assert property (@(posedge clk) disable iff (rst)
    (keep_sign && !enc_zero) |-> (result[DATA_W-2] && result[DATA_W-1] == d1[DATA_W-1]));

  logic [DATA_W-1:0] res_q;
  logic [OUT_W-1:0]  s2_bus;

  ns_stage #(.W(OUT_W)) u_out_stage (
    .clk(clk), .rst(rst), .ce(ce), .bypass(out_bypass),
    .d({result, enc_cnt, enc_zero}), .q(s2_bus)
  );

  assign {res_q, lead_count, lead_zero} = s2_bus;
  assign data_out = half_sel ? res_q[DATA_W-1 -: HALF_W] : res_q[HALF_W-1:0];

endmodule

// File: tb/test_norm_shifter.sv
module test_norm_shifter;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic        in_bypass = 1'b0;
  logic        out_bypass = 1'b0;
  logic [31:0] data_in = '0;
  logic [4:0]  shift_amt = '0;
  logic [1:0]  shift_op = '0;
  logic        fill_sign = 1'b0;
  logic        normalize = 1'b0;
  logic        sm_mode = 1'b0;
  logic        half_sel = 1'b0;
  logic [15:0] data_out;
  logic [4:0]  lead_count;
  logic        lead_zero;

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R10";

  always #(CLK_P/2) clk = ~clk;

  norm_shifter i_norm_shifter (
    .clk(clk), .rst(rst), .ce(ce), .in_bypass(in_bypass), .out_bypass(out_bypass),
    .data_in(data_in), .shift_amt(shift_amt), .shift_op(shift_op),
    .fill_sign(fill_sign), .normalize(normalize), .sm_mode(sm_mode),
    .half_sel(half_sel), .data_out(data_out), .lead_count(lead_count),
    .lead_zero(lead_zero)
  );

  // Behavioural reference: result, count and flag for one stage-1 vector
  function automatic logic [37:0] ref_calc(input logic [31:0] d, input logic [4:0] sh,
      input logic [1:0] op, input logic fs, input logic nm, input logic sm);
    int          c = 0;
    int          a;
    logic        s;
    logic [63:0] dd;
    logic [31:0] r;
    logic        left;
    s = sm ? 1'b0 : d[31];
    for (int i = 30; i >= 0; i--) begin
      if (d[i] != s) break;
      c++;
    end
    left = (op == 2'b01) || (op == 2'b11);
    a = (nm && left) ? c : int'(sh);
    if (op == 2'b00) begin
      dd = {d, d} << a;
      r  = dd[63:32];
    end else if (op == 2'b10) begin
      r = fs ? 32'($signed(d) >>> a) : (d >> a);
    end else if (nm && sm) begin
      r = {d[31], 31'(d[30:0] << a)};
    end else begin
      r = d << a;
    end
    return {r, 5'(c), (c == 31)};
  endfunction

  // reference pipeline held as plain variables
  logic [31:0] m_d;  logic [4:0] m_sh; logic [1:0] m_op;
  logic m_fs, m_nm, m_sm;
  logic [37:0] m_out;
  logic [37:0] ex_now, ex_s2;

  always_comb begin
    if (in_bypass)
      ex_now = ref_calc(data_in, shift_amt, shift_op, fill_sign, normalize, sm_mode);
    else
      ex_now = ref_calc(m_d, m_sh, m_op, m_fs, m_nm, m_sm);
    ex_s2 = out_bypass ? ex_now : m_out;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_d <= '0; m_sh <= '0; m_op <= '0; m_fs <= 0; m_nm <= 0; m_sm <= 0; m_out <= '0;
    end else if (ce) begin
      m_d <= data_in; m_sh <= shift_amt; m_op <= shift_op;
      m_fs <= fill_sign; m_nm <= normalize; m_sm <= sm_mode;
      m_out <= ex_now;
    end
  end

  task automatic check_now();
    logic [15:0] e_d;
    e_d = half_sel ? ex_s2[37:22] : ex_s2[21:6];
    n_vec++;
    if (data_out !== e_d || lead_count !== ex_s2[5:1] || lead_zero !== ex_s2[0]) begin
      n_bad++;
      $display("FAIL %s: out=%h cnt=%0d z=%b expected out=%h cnt=%0d z=%b",
               phase, data_out, lead_count, lead_zero, e_d, ex_s2[5:1], ex_s2[0]);
    end
  endtask

  task automatic step(input logic [31:0] d, input logic [4:0] sh, input logic [1:0] op,
                      input logic fs, input logic nm, input logic sm);
    @(negedge clk);
    data_in = d; shift_amt = sh; shift_op = op;
    fill_sign = fs; normalize = nm; sm_mode = sm;
    half_sel = ~half_sel;
    #(CLK_P/4);
    check_now();
  endtask

  function automatic logic [31:0] biased();
    logic [31:0] v;
    v = $urandom >> ($urandom % 32);
    if ($urandom % 2) v = ~v;
    return v;
  endfunction

  task automatic rand_steps(input int n);
    for (int i = 0; i < n; i++)
      step(biased(), 5'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(17));
    // R10: reset state, outputs zero
    phase = "R10";
    step(32'hDEAD_BEEF, 5'd3, 2'b01, 0, 0, 0);
    step(32'hDEAD_BEEF, 5'd3, 2'b01, 0, 0, 0);
    rst = 1'b0;
    // R1: rotate left
    phase = "R1";
    step(32'h8000_0001, 5'd0, 2'b00, 0, 0, 0);
    step(32'h8000_0001, 5'd1, 2'b00, 0, 0, 0);
    step(32'h8000_0001, 5'd31, 2'b00, 0, 0, 0);
    step(32'h1234_5678, 5'd16, 2'b00, 0, 1, 0);
    // R2: left shift zero fill, both encodings
    phase = "R2";
    step(32'hFFFF_FFFF, 5'd4, 2'b01, 1, 0, 0);
    step(32'hFFFF_FFFF, 5'd31, 2'b11, 0, 0, 0);
    step(32'h0F0F_0F0F, 5'd0, 2'b01, 0, 0, 0);
    // R3: right shift, sign and zero fill
    phase = "R3";
    step(32'h8000_0000, 5'd31, 2'b10, 1, 0, 0);
    step(32'h8000_0000, 5'd31, 2'b10, 0, 0, 0);
    step(32'hF000_1234, 5'd8, 2'b10, 1, 1, 0);
    step(32'h7000_1234, 5'd8, 2'b10, 1, 0, 0);
    // R4: same word shown as both halves
    phase = "R4";
    step(32'hABCD_1234, 5'd0, 2'b00, 0, 0, 0);
    step(32'hABCD_1234, 5'd0, 2'b00, 0, 0, 0);
    step(32'hABCD_1234, 5'd0, 2'b00, 0, 0, 0);
    // R5: two's-complement normalization ignores shift_amt
    phase = "R5";
    step(32'h0000_1000, 5'd7, 2'b01, 0, 1, 0);
    step(32'hFFFF_F000, 5'd2, 2'b11, 0, 1, 0);
    step(32'h4000_0000, 5'd9, 2'b01, 0, 1, 0);
    // R6: sign-magnitude normalization keeps the sign bit
    phase = "R6";
    step(32'h8000_0003, 5'd0, 2'b01, 0, 1, 1);
    step(32'h0000_0001, 5'd0, 2'b01, 0, 1, 1);
    step(32'hC000_0000, 5'd5, 2'b11, 0, 1, 1);
    // R7: count on its own port under every operation
    phase = "R7";
    step(32'h0010_0000, 5'd3, 2'b00, 0, 0, 0);
    step(32'hFFF0_0000, 5'd3, 2'b10, 1, 0, 0);
    step(32'h8010_0000, 5'd3, 2'b10, 0, 0, 1);
    // R8: all-zero and all-sign words
    phase = "R8";
    step(32'h0000_0000, 5'd0, 2'b01, 0, 1, 0);
    step(32'hFFFF_FFFF, 5'd0, 2'b01, 0, 1, 0);
    step(32'h8000_0000, 5'd0, 2'b01, 0, 1, 1);
    step(32'h0000_0000, 5'd0, 2'b01, 0, 1, 1);
    step(32'h0000_0000, 5'd0, 2'b00, 0, 0, 0);
    step(32'h0000_0000, 5'd0, 2'b00, 0, 0, 0);
    // R9: every bypass combination
    phase = "R9";
    for (int b = 0; b < 4; b++) begin
      in_bypass  = b[0];
      out_bypass = b[1];
      rand_steps(300);
    end
    in_bypass = 0; out_bypass = 0;
    // R10: enable toggling and reset in mid-stream
    phase = "R10";
    for (int i = 0; i < 400; i++) begin
      ce = 1'($urandom % 3 != 0);
      if (i == 200) rst = 1'b1;
      if (i == 203) rst = 1'b0;
      rand_steps(1);
    end
    ce = 1'b1;
    // R9: mixed random run with changing bypass
    phase = "R9";
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) begin
        in_bypass  = 1'($urandom);
        out_bypass = 1'($urandom);
      end
      rand_steps(1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule